// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs, in one clock, everything a 32-bit soft processor must do when it leaves normal flow for a handler. The four kinds of entry are an external interrupt, a hardware break, a hardware exception (including a misaligned data access) and a memory-management fault. A one-cycle request carries the kind of entry. With it come the current program counter, the pipeline's delay-slot and immediate-prefix state, the pending branch target, the fault address and access kind, and the machine status word.

From these the block computes the handler address, the link register number and the return address, and the new status word. The return address accounts for a faulting instruction that sits in a delay slot or behind an immediate prefix. In the new status word the user-mode and virtual-memory bits are stacked into their saved copies. The block also holds the exception status, exception address and branch-target registers, and the load-reserved reservation flag.

Interrupts pass an acceptance gate before they are taken. A memory fault raised while an exception is already in progress latches a double-fault error, and the block then writes nothing more until reset. After every accepted entry a one-cycle `done` pulse appears. It is the write strobe for the new PC, the link register and the status word, and it tells the pipeline to drop its delay-slot and prefix flags.

Top module: `trap_entry_unit`

## Requirements
- R1: `pcNext` is `VEC_BASE`+0x10 after an interrupt, +0x18 after a break, and +0x20 after a hardware exception, misaligned access or memory fault. Request kind codes: 0 interrupt, 1 break, 2 hardware exception, 3 memory fault, 4 misaligned access. Kinds 5 to 7 are ignored.
- R2: On every entry `msrNext` copies user-mode (bit 11) into bit 12 and virtual-memory (bit 13) into bit 14, then clears bits 11 and 13. All other bits pass through, except as R3 states.
- R3: An interrupt entry clears interrupt-enable (bit 1). A break sets break-in-progress (bit 3). A hardware exception, misaligned access or memory fault sets exception-in-progress (bit 9).
- R4: An interrupt request is taken only when bit 1 of `msrIn` is set, bits 3 and 9 are clear, and neither `inDelaySlot` nor `immPrefixed` is set. Otherwise it produces no `done` and changes no output.
- R5: The link outputs take these values. Interrupt: index 14, value PC. Break: index 16, value PC. Hardware exception or misaligned access: index 17, value PC+4. Memory fault: index 17, value PC.
- R6: For a memory fault in a delay slot, the link value is PC-4, or PC-8 if `branchImm` is set. Outside a delay slot it is PC-4 when `immPrefixed` is set.
- R7: A hardware exception, misaligned access or memory fault sets ESR bit 12 and loads `btr` with `branchTarget` when `inDelaySlot` is set. Otherwise it clears bit 12 and leaves `btr` unchanged.
- R8: A memory fault writes an ESR of 0 apart from three fields. Bits 4:0 hold the cause: 17 for a fetch protection fault, 16 for a data protection fault, 19 for a fetch miss and 18 for a data miss. Bit 10 is set for a store, and bit 12 follows R7. `ear` takes `faultAddr`. Access codes: 0 fetch, 1 load, 2 store.
- R9: A misaligned access writes an ESR of cause 1 in bits 4:0 and `syndrome` in bits 11:5, plus bit 12 per R7. It loads `ear` with `faultAddr`. A plain hardware exception keeps the ESR bits other than bit 12.
- R10: With `EXC_EN`=0, hardware-exception and misaligned-access requests produce no `done`. Memory faults are still taken.
- R11: Every accepted entry clears `resValid`, and this wins over a `resSet` in the same cycle. A `resSet` on its own sets `resValid`.
- R12: A memory-fault request while bit 9 of `msrIn` is set raises a sticky `dblFault`. That request, and every later one until reset, produces no `done` and no register write.
- R13: All outputs of one entry change on the same clock edge, and `done` is high for exactly the cycle after that edge. Reset clears `done`, `dblFault`, `resValid` and all value outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | One-cycle entry request |
| evtKind | input | 3 | Kind of entry (codes in R1) |
| pcIn | input | 32 | PC of the current instruction |
| inDelaySlot | input | 1 | Current instruction is in a branch delay slot |
| immPrefixed | input | 1 | Current instruction carries an immediate prefix |
| branchImm | input | 1 | The pending branch carried an immediate prefix |
| branchTarget | input | 32 | Target of the pending branch |
| faultAddr | input | 32 | Faulting data or fetch address |
| accessKind | input | 2 | Access kind of the fault (codes in R8) |
| faultIsMiss | input | 1 | 1 = translation miss, 0 = protection fault |
| syndrome | input | 7 | Instruction-specific bits for a misaligned access |
| msrIn | input | 32 | Current machine status word |
| resSet | input | 1 | A load-reserved sets the reservation |
| done | output | 1 | Entry committed; write strobe for PC, link and status |
| pcNext | output | 32 | Handler address |
| linkIdx | output | 5 | Register number for the return address |
| linkVal | output | 32 | Return address |
| msrNext | output | 32 | Status word after entry |
| esr | output | 32 | Exception status register |
| ear | output | 32 | Exception address register |
| btr | output | 32 | Branch target register |
| resValid | output | 1 | Reservation valid |
| dblFault | output | 1 | Sticky double-fault error |

## Verification
A load-reserved can set the reservation in the same cycle that an accepted entry invalidates it. The bench provokes this by raising `resSet` together with an interrupt request, and requires `resValid` to read 0 afterwards. A second collision can also occur: a memory fault arrives while the incoming status word already shows an exception in progress, so the fault path and the double-fault path compete. That case is judged by requiring `dblFault` high, no `done`, and `esr`, `ear` and `pcNext` unchanged, and then requiring a following break to be refused too.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    EV_IRQ  = 3'd0,
    EV_BRK  = 3'd1,
    EV_HWX  = 3'd2,
    EV_MMU  = 3'd3,
    EV_UNAL = 3'd4
  } evKind_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } accKind_e;

  // status word bit positions
  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_VM  = 13;
  localparam int MSR_UMS = MSR_UM + 1;
  localparam int MSR_VMS = MSR_VM + 1;

  // exception status fields
  localparam int ESR_CAUSE_W = 5;
  localparam int ESR_SYN_LSB = 5;
  localparam int SYN_W       = 7;
  localparam int ESR_STORE   = 10;
  localparam int ESR_DS      = 12;
  localparam logic [ESR_CAUSE_W-1:0] CAUSE_UNAL = 5'd1;

  // link register numbers
  localparam int IDX_W = 5;
  localparam logic [IDX_W-1:0] LINK_IRQ = 5'd14;
  localparam logic [IDX_W-1:0] LINK_BRK = 5'd16;
  localparam logic [IDX_W-1:0] LINK_EXC = 5'd17;

  // vector offsets
  localparam int VOFF_IRQ = 'h10;
  localparam int VOFF_BRK = 'h18;
  localparam int VOFF_EXC = 'h20;

  typedef struct packed {
    logic commit;
    logic isIrq;
    logic isBrk;
    logic isHwx;
    logic isUnal;
    logic isMmu;
  } strobe_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter bit EXC_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtValid,
  input  logic [2:0]  evtKind,
  input  logic        msrIe,
  input  logic        msrEip,
  input  logic        msrBip,
  input  logic        inDelaySlot,
  input  logic        immPrefixed,
  output strobe_t     stb,
  output logic        done,
  output logic        dblFault
);
  logic kIrq, kBrk, kHwx, kUnal, kMmu;
  logic irqOk, excOk, accept, dblTrig;

  assign kIrq  = (evtKind == EV_IRQ);
  assign kBrk  = (evtKind == EV_BRK);
  assign kHwx  = (evtKind == EV_HWX);
  assign kUnal = (evtKind == EV_UNAL);
  assign kMmu  = (evtKind == EV_MMU);

  generate
    if (EXC_EN) begin : g_excOn
      assign excOk = 1'b1;
    end else begin : g_excOff
      assign excOk = 1'b0;
    end
  endgenerate

  assign irqOk = msrIe && !msrEip && !msrBip && !inDelaySlot && !immPrefixed;

  always_comb begin
    accept = 1'b0;
    if (kIrq)                accept = irqOk;
    else if (kBrk)           accept = 1'b1;
    else if (kHwx || kUnal)  accept = excOk;
    else if (kMmu)           accept = !msrEip;
  end

  assign dblTrig = evtValid && !dblFault && kMmu && msrEip;

  always_comb begin
    stb        = '0;
    stb.commit = evtValid && !dblFault && accept;
    stb.isIrq  = kIrq;
    stb.isBrk  = kBrk;
    stb.isHwx  = kHwx;
    stb.isUnal = kUnal;
    stb.isMmu  = kMmu;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done     <= 1'b0;
      dblFault <= 1'b0;
    end else begin
      done <= stb.commit;
      if (dblTrig) dblFault <= 1'b1;
    end
  end
endmodule

// File: rtl/trap_dpath.sv
module trap_dpath
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_BASE = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [XLEN-1:0]   pcIn,
  input  logic              inDelaySlot,
  input  logic              immPrefixed,
  input  logic              branchImm,
  input  logic [XLEN-1:0]   branchTarget,
  input  logic [XLEN-1:0]   faultAddr,
  input  logic [1:0]        accessKind,
  input  logic              faultIsMiss,
  input  logic [SYN_W-1:0]  syndrome,
  input  logic [XLEN-1:0]   msrIn,
  input  logic              resSet,
  output logic [XLEN-1:0]   pcNext,
  output logic [IDX_W-1:0]  linkIdx,
  output logic [XLEN-1:0]   linkVal,
  output logic [XLEN-1:0]   msrNext,
  output logic [XLEN-1:0]   esr,
  output logic [XLEN-1:0]   ear,
  output logic [XLEN-1:0]   btr,
  output logic              resValid
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic              isExc;
  logic [XLEN-1:0]   vecOff, pcD, linkValD, msrD, esrD, earD, btrD, mmuAdj;
  logic [IDX_W-1:0]  linkIdxD;

  assign isExc = stb.isHwx || stb.isUnal || stb.isMmu;

  // return-address correction for a memory fault
  always_comb begin
    if (inDelaySlot)      mmuAdj = branchImm ? (STEP << 1) : STEP;
    else if (immPrefixed) mmuAdj = STEP;
    else                  mmuAdj = '0;
  end

  always_comb begin
    vecOff   = XLEN'(VOFF_EXC);
    linkIdxD = LINK_EXC;
    linkValD = pcIn + STEP;
    if (stb.isIrq) begin
      vecOff   = XLEN'(VOFF_IRQ);
      linkIdxD = LINK_IRQ;
      linkValD = pcIn;
    end else if (stb.isBrk) begin
      vecOff   = XLEN'(VOFF_BRK);
      linkIdxD = LINK_BRK;
      linkValD = pcIn;
    end else if (stb.isMmu) begin
      linkValD = pcIn - mmuAdj;
    end
    pcD = VEC_BASE + vecOff;
  end

  // status word: stack mode bits, then per-kind flag
  always_comb begin
    msrD          = msrIn;
    msrD[MSR_UMS] = msrIn[MSR_UM];
    msrD[MSR_VMS] = msrIn[MSR_VM];
    msrD[MSR_UM]  = 1'b0;
    msrD[MSR_VM]  = 1'b0;
    if (stb.isIrq)      msrD[MSR_IE]  = 1'b0;
    else if (stb.isBrk) msrD[MSR_BIP] = 1'b1;
    else                msrD[MSR_EIP] = 1'b1;
  end

  // exception status / address / branch target
  always_comb begin
    esrD = esr;
    earD = ear;
    btrD = btr;
    if (stb.isMmu) begin
      esrD = '0;
      esrD[ESR_CAUSE_W-1:0] = {3'b100, faultIsMiss, accessKind == ACC_FETCH};
      esrD[ESR_STORE]       = (accessKind == ACC_STORE);
      earD                  = faultAddr;
    end else if (stb.isUnal) begin
      esrD = '0;
      esrD[ESR_CAUSE_W-1:0]        = CAUSE_UNAL;
      esrD[ESR_SYN_LSB +: SYN_W]   = syndrome;
      earD                         = faultAddr;
    end
    if (isExc) begin
      esrD[ESR_DS] = inDelaySlot;
      if (inDelaySlot) btrD = branchTarget;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcNext   <= '0;
      linkIdx  <= '0;
      linkVal  <= '0;
      msrNext  <= '0;
      esr      <= '0;
      ear      <= '0;
      btr      <= '0;
      resValid <= 1'b0;
    end else begin
      if (stb.commit) begin
        pcNext  <= pcD;
        linkIdx <= linkIdxD;
        linkVal <= linkValD;
        msrNext <= msrD;
        if (!stb.isIrq && !stb.isBrk) begin
          esr <= esrD;
          ear <= earD;
          btr <= btrD;
        end
        resValid <= 1'b0;
      end else if (resSet) begin
        resValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_BASE = 32'h0000_0100,
  parameter bit EXC_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  input  logic [2:0]       evtKind,
  input  logic [XLEN-1:0]  pcIn,
  input  logic             inDelaySlot,
  input  logic             immPrefixed,
  input  logic             branchImm,
  input  logic [XLEN-1:0]  branchTarget,
  input  logic [XLEN-1:0]  faultAddr,
  input  logic [1:0]       accessKind,
  input  logic             faultIsMiss,
  input  logic [6:0]       syndrome,
  input  logic [XLEN-1:0]  msrIn,
  input  logic             resSet,
  output logic             done,
  output logic [XLEN-1:0]  pcNext,
  output logic [4:0]       linkIdx,
  output logic [XLEN-1:0]  linkVal,
  output logic [XLEN-1:0]  msrNext,
  output logic [XLEN-1:0]  esr,
  output logic [XLEN-1:0]  ear,
  output logic [XLEN-1:0]  btr,
  output logic             resValid,
  output logic             dblFault
);
  strobe_t stb;

  trap_ctrl #(.EXC_EN(EXC_EN)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind),
    .msrIe(msrIn[MSR_IE]), .msrEip(msrIn[MSR_EIP]), .msrBip(msrIn[MSR_BIP]),
    .inDelaySlot(inDelaySlot), .immPrefixed(immPrefixed),
    .stb(stb), .done(done), .dblFault(dblFault)
  );

  trap_dpath #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .pcIn(pcIn),
    .inDelaySlot(inDelaySlot), .immPrefixed(immPrefixed), .branchImm(branchImm),
    .branchTarget(branchTarget), .faultAddr(faultAddr), .accessKind(accessKind),
    .faultIsMiss(faultIsMiss), .syndrome(syndrome), .msrIn(msrIn), .resSet(resSet),
    .pcNext(pcNext), .linkIdx(linkIdx), .linkVal(linkVal), .msrNext(msrNext),
    .esr(esr), .ear(ear), .btr(btr), .resValid(resValid)
  );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_BASE = 32'h0000_0100
) (
  input logic             clk,
  input logic             rstN,
  input logic             evtValid,
  input logic [2:0]       evtKind,
  input logic [XLEN-1:0]  pcIn,
  input logic             inDelaySlot,
  input logic             branchImm,
  input logic [XLEN-1:0]  msrIn,
  input logic             done,
  input logic [XLEN-1:0]  pcNext,
  input logic [4:0]       linkIdx,
  input logic [XLEN-1:0]  linkVal,
  input logic [XLEN-1:0]  msrNext,
  input logic             resValid,
  input logic             dblFault
);
  p_done_cause_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(evtValid));

  p_brk_vector_r1: assert property (@(posedge clk) disable iff (!rstN)
    (done && linkIdx == LINK_BRK) |-> pcNext == VEC_BASE + XLEN'('h18));

  p_mode_stack_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!msrNext[MSR_UM] && !msrNext[MSR_VM] &&
              msrNext[MSR_UMS] == $past(msrIn[MSR_UM]) &&
              msrNext[MSR_VMS] == $past(msrIn[MSR_VM])));

  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && linkIdx == LINK_IRQ) |-> ($past(msrIn[MSR_IE]) && !$past(msrIn[MSR_EIP]) &&
                                       !$past(msrIn[MSR_BIP]) && !$past(inDelaySlot)));

  p_mmu_rewind_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(evtKind) == EV_MMU && $past(inDelaySlot) && $past(branchImm))
      |-> linkVal == $past(pcIn) - XLEN'(8));

  p_res_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !resValid);

  p_dbl_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    dblFault |=> dblFault);

  p_dbl_silent_r12: assert property (@(posedge clk) disable iff (!rstN)
    $past(dblFault) |-> !done);
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind), .pcIn(pcIn),
  .inDelaySlot(inDelaySlot), .branchImm(branchImm), .msrIn(msrIn), .done(done),
  .pcNext(pcNext), .linkIdx(linkIdx), .linkVal(linkVal), .msrNext(msrNext),
  .resValid(resValid), .dblFault(dblFault)
);

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic [2:0] evtKind = '0;
  logic [31:0] pcIn = '0, branchTarget = '0, faultAddr = '0, msrIn = '0;
  logic inDelaySlot = 1'b0, immPrefixed = 1'b0, branchImm = 1'b0;
  logic [1:0] accessKind = '0;
  logic faultIsMiss = 1'b0;
  logic [6:0] syndrome = '0;
  logic resSet = 1'b0;
  logic done, resValid, dblFault, doneN;
  logic [31:0] pcNext, linkVal, msrNext, esr, ear, btr;
  logic [4:0] linkIdx;
  logic [31:0] pcNextN, linkValN, msrNextN, esrN, earN, btrN;
  logic [4:0] linkIdxN;
  logic resValidN, dblFaultN;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  trap_entry_unit #(.VEC_BASE(32'h0000_0100)) uut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind), .pcIn(pcIn),
    .inDelaySlot(inDelaySlot), .immPrefixed(immPrefixed), .branchImm(branchImm),
    .branchTarget(branchTarget), .faultAddr(faultAddr), .accessKind(accessKind),
    .faultIsMiss(faultIsMiss), .syndrome(syndrome), .msrIn(msrIn), .resSet(resSet),
    .done(done), .pcNext(pcNext), .linkIdx(linkIdx), .linkVal(linkVal),
    .msrNext(msrNext), .esr(esr), .ear(ear), .btr(btr), .resValid(resValid),
    .dblFault(dblFault));

  trap_entry_unit #(.VEC_BASE(32'h0000_0100), .EXC_EN(1'b0)) uutNoExc (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind), .pcIn(pcIn),
    .inDelaySlot(inDelaySlot), .immPrefixed(immPrefixed), .branchImm(branchImm),
    .branchTarget(branchTarget), .faultAddr(faultAddr), .accessKind(accessKind),
    .faultIsMiss(faultIsMiss), .syndrome(syndrome), .msrIn(msrIn), .resSet(resSet),
    .done(doneN), .pcNext(pcNextN), .linkIdx(linkIdxN), .linkVal(linkValN),
    .msrNext(msrNextN), .esr(esrN), .ear(earN), .btr(btrN), .resValid(resValidN),
    .dblFault(dblFaultN));

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] pc;
    logic        ds;
    logic        imm;
    logic        bimm;
    logic [1:0]  acc;
    logic        miss;
    logic [6:0]  syn;
    logic [31:0] msr;
    logic [31:0] fa;
    logic [31:0] expPc;
    logic [4:0]  expIdx;
    logic [31:0] expLink;
    logic [31:0] expMsr;
    logic [31:0] expEsr;
    logic [31:0] esrMask;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h2000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h00, 32'h2802, 32'h0, 32'h110, 5'd14, 32'h2000, 32'h5000, 32'h0, 32'h0},
    '{3'd1, 32'h3004, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h00, 32'h0800, 32'h0, 32'h118, 5'd16, 32'h3004, 32'h1008, 32'h0, 32'h0},
    '{3'd2, 32'h4000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h00, 32'h2000, 32'h0, 32'h120, 5'd17, 32'h4004, 32'h4200, 32'h0, 32'h1000},
    '{3'd2, 32'h4008, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 7'h00, 32'h0002, 32'h0, 32'h120, 5'd17, 32'h400C, 32'h0202, 32'h1000, 32'h1000},
    '{3'd3, 32'h6000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h00, 32'h0000, 32'hA000_6000, 32'h120, 5'd17, 32'h6000, 32'h0200, 32'h11, 32'hFFFF_FFFF},
    '{3'd3, 32'h6010, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 7'h00, 32'h0000, 32'hA000_6010, 32'h120, 5'd17, 32'h600C, 32'h0200, 32'h10, 32'hFFFF_FFFF},
    '{3'd3, 32'h6020, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 7'h00, 32'h0000, 32'hA000_6020, 32'h120, 5'd17, 32'h601C, 32'h0200, 32'h1412, 32'hFFFF_FFFF},
    '{3'd3, 32'h6030, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 7'h00, 32'h0000, 32'hA000_6030, 32'h120, 5'd17, 32'h6028, 32'h0200, 32'h1013, 32'hFFFF_FFFF},
    '{3'd3, 32'h6040, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 7'h00, 32'h0000, 32'hA000_6040, 32'h120, 5'd17, 32'h6040, 32'h0200, 32'h410, 32'hFFFF_FFFF},
    '{3'd4, 32'h7000, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 7'h55, 32'h0000, 32'hB000_7001, 32'h120, 5'd17, 32'h7004, 32'h0200, 32'hAA1, 32'hFFFF_FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request at a falling edge; return after the next falling edge
  task automatic fire(input logic [2:0] k, input logic [31:0] pc, input logic ds,
                      input logic imm, input logic bimm, input logic [1:0] acc,
                      input logic miss, input logic [6:0] syn, input logic [31:0] msr,
                      input logic [31:0] fa, input logic [31:0] bt, input logic rs);
    @(negedge clk);
    evtValid = 1'b1; evtKind = k; pcIn = pc; inDelaySlot = ds; immPrefixed = imm;
    branchImm = bimm; accessKind = acc; faultIsMiss = miss; syndrome = syn;
    msrIn = msr; faultAddr = fa; branchTarget = bt; resSet = rs;
    @(negedge clk);
    evtValid = 1'b0; resSet = 1'b0; inDelaySlot = 1'b0; immPrefixed = 1'b0; branchImm = 1'b0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 reset done", {31'b0, done}, 32'h0);
    check("R13 reset pcNext", pcNext, 32'h0);
    check("R13 reset esr", esr, 32'h0);
    check("R13 reset resValid", {31'b0, resValid}, 32'h0);
    check("R13 reset dblFault", {31'b0, dblFault}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R5 R6 R8 R9
    for (int i = 0; i < NV; i++) begin
      fire(VECS[i].kind, VECS[i].pc, VECS[i].ds, VECS[i].imm, VECS[i].bimm, VECS[i].acc,
           VECS[i].miss, VECS[i].syn, VECS[i].msr, VECS[i].fa, 32'h5550, 1'b0);
      check($sformatf("R13 done vec%0d", i), {31'b0, done}, 32'h1);
      check($sformatf("R1 pc vec%0d", i), pcNext, VECS[i].expPc);
      check($sformatf("R5 idx vec%0d", i), {27'b0, linkIdx}, {27'b0, VECS[i].expIdx});
      check($sformatf("R6 link vec%0d", i), linkVal, VECS[i].expLink);
      check($sformatf("R2 R3 msr vec%0d", i), msrNext, VECS[i].expMsr);
      check($sformatf("R8 R9 esr vec%0d", i), esr & VECS[i].esrMask, VECS[i].expEsr);
      if (VECS[i].kind == 3'd3 || VECS[i].kind == 3'd4)
        check($sformatf("R8 R9 ear vec%0d", i), ear, VECS[i].fa);
    end
    @(negedge clk);
    check("R13 done single cycle", {31'b0, done}, 32'h0);

    // R7 delay-slot branch target capture, then non-delay leaves btr
    fire(3'd2, 32'h8000, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 7'h0, 32'h0, 32'h0, 32'hCAFE_0000, 1'b0);
    check("R7 btr loaded", btr, 32'hCAFE_0000);
    check("R7 esr ds set", esr & 32'h1000, 32'h1000);
    fire(3'd3, 32'h8010, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 7'h0, 32'h0, 32'h1234, 32'hDEAD_0000, 1'b0);
    check("R7 btr kept", btr, 32'hCAFE_0000);
    check("R7 esr ds clear", esr & 32'h1000, 32'h0);

    // R9 plain hardware exception keeps other ESR bits (0x10 from last fault)
    fire(3'd2, 32'h8020, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h0, 32'h0, 32'h0, 32'h0, 1'b0);
    check("R9 hwx keeps esr", esr, 32'h10);

    // R4 interrupt gate rejections
    fire(3'd0, 32'h9000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h0, 32'h0000, 32'h0, 32'h0, 1'b0);
    check("R4 ie clear refused", {31'b0, done}, 32'h0);
    fire(3'd0, 32'h9000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h0, 32'h0202, 32'h0, 32'h0, 1'b0);
    check("R4 eip refused", {31'b0, done}, 32'h0);
    fire(3'd0, 32'h9000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h0, 32'h000A, 32'h0, 32'h0, 1'b0);
    check("R4 bip refused", {31'b0, done}, 32'h0);
    fire(3'd0, 32'h9000, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 7'h0, 32'h0002, 32'h0, 32'h0, 1'b0);
    check("R4 delay slot refused", {31'b0, done}, 32'h0);
    fire(3'd0, 32'h9000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 7'h0, 32'h0002, 32'h0, 32'h0, 1'b0);
    check("R4 prefix refused", {31'b0, done}, 32'h0);
    check("R4 pc unchanged", pcNext, 32'h120);
    check("R4 link unchanged", linkVal, 32'h8024);
    fire(3'd5, 32'h9100, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h0, 32'h0002, 32'h0, 32'h0, 1'b0);
    check("R1 unknown kind refused", {31'b0, done}, 32'h0);

    // R10 no-exception instance
    fire(3'd2, 32'hA000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h0, 32'h0, 32'h0, 32'h0, 1'b0);
    check("R10 hwx ignored", {31'b0, doneN}, 32'h0);
    check("R10 hwx pc held", pcNextN, 32'h120);
    fire(3'd4, 32'hA004, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 7'h3, 32'h0, 32'h44, 32'h0, 1'b0);
    check("R10 unaligned ignored", {31'b0, doneN}, 32'h0);
    check("R10 ear held", earN, 32'h1234);
    fire(3'd3, 32'hA008, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h0, 32'h0, 32'h88, 32'h0, 1'b0);
    check("R10 mmu still taken", {31'b0, doneN}, 32'h1);

    // R11 reservation
    @(negedge clk); resSet = 1'b1;
    @(negedge clk); resSet = 1'b0;
    check("R11 resSet sets", {31'b0, resValid}, 32'h1);
    fire(3'd0, 32'hB000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h0, 32'h0002, 32'h0, 32'h0, 1'b1);
    check("R11 entry beats resSet done", {31'b0, done}, 32'h1);
    check("R11 entry beats resSet", {31'b0, resValid}, 32'h0);

    // R12 double fault
    keep = esr;
    fire(3'd3, 32'hC000, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 7'h0, 32'h0200, 32'hFFFF_0000, 32'h0, 1'b0);
    check("R12 dbl raised", {31'b0, dblFault}, 32'h1);
    check("R12 no done", {31'b0, done}, 32'h0);
    check("R12 esr held", esr, keep);
    check("R12 pc held", pcNext, 32'h110);
    fire(3'd1, 32'hC004, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 7'h0, 32'h0, 32'h0, 32'h0, 1'b0);
    check("R12 later break refused", {31'b0, done}, 32'h0);
    check("R12 sticky", {31'b0, dblFault}, 32'h1);

    // R13 reset clears the error
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R13 reset clears dbl", {31'b0, dblFault}, 32'h0);
    check("R13 reset clears ear", ear, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule